// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the datapath of a small processor in which every register exchanges data over one shared internal bus. It holds a program counter, a memory address register, a memory data register, an instruction register, a bank of general registers, an operand holding register Y, an arithmetic unit and a result register Z. An external controller drives the block. For each register it asserts an enable that puts the register on the bus and an enable that loads the register from the bus. It also picks the arithmetic operation and sets the carry input.

The arithmetic unit has three operands: Y, the value on the bus and a one-bit carry. Its result is written into Z, and Z can then drive the bus. No dedicated incrementer exists. To advance the program counter, the controller puts the PC on the bus, clears Y, sets the carry and selects add. Reads are started by loading the address register with the read request asserted. The memory signals completion, and the returned word is then captured into the data register. Several bus drivers enabled at once raise an error flag, and a fixed priority picks the winner.

Top module: `sbus_datapath`

## Requirements
- R1: After reset the program counter holds RESET_PC (default 1000), the read request is low, and Y, Z, the data register, the instruction register and all general registers hold 0.
- R2: The bus is a priority mux. From highest to lowest priority the sources are PC, data register, instruction address field, Z, then the general registers with index 0 first. The address field is the low 12 bits of the instruction register, zero-extended. With no source enabled the bus reads 0.
- R3: bus_err is high in the same cycle whenever two or more bus-out enables are asserted, and low otherwise.
- R4: With z_in high, Z loads the unit result at the clock edge. alu_op 0 gives Y+bus+carry, 1 gives Y−bus, 2 gives the low 16 bits of Y×bus, and 3 gives Y/bus. Division by zero gives 16'hFFFF.
- R5: y_clr makes the unit see Y as 0 in the same cycle and clears Y at the edge, taking priority over y_in. With carry set and add selected, Z receives bus+1.
- R6: mar_in together with rd_start captures the bus into mem_addr and raises rd_req on the next cycle. rd_req and mem_addr then hold until mem_done. mem_done while rd_req is high loads the data register with mem_rdata and drops rd_req. mem_done with no pending read changes nothing.
- R7: zero_o is updated only when Z loads. It is then 1 exactly when the loaded result is 0.
- R8: Each register loads the bus value at the clock edge when its in enable is high, and otherwise holds its value.
- R9: From reset, with R1 = 30, the word at 1000 encoding address field 200, and mem[200] = 12, the fetch and add control sequence leaves R1 = 42 and PC = 1001.
- R10: A jump sequence (PC to Y, then address field plus Y into Z, then Z into PC) sets PC to the incremented PC plus the address field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_out | input | 1 | PC drives bus |
| pc_in | input | 1 | PC loads bus |
| mar_in | input | 1 | Address register loads bus |
| rd_start | input | 1 | Start a read with mar_in |
| mdr_out | input | 1 | Data register drives bus |
| ir_in | input | 1 | Instruction register loads bus |
| ir_addr_out | input | 1 | Instruction address field drives bus |
| y_in | input | 1 | Y loads bus |
| y_clr | input | 1 | Clear Y, unit sees 0 |
| z_in | input | 1 | Z loads unit result |
| z_out | input | 1 | Z drives bus |
| reg_out | input | NREG | General register out enables |
| reg_in | input | NREG | General register in enables |
| carry | input | 1 | Carry operand |
| alu_op | input | 2 | 0 add, 1 sub, 2 mul, 3 div |
| mem_addr | output | W | Read address |
| rd_req | output | 1 | Read pending |
| mem_rdata | input | W | Returned word |
| mem_done | input | 1 | Read completed |
| bus_o | output | W | Internal bus value |
| pc_o | output | W | Program counter |
| zero_o | output | 1 | Last Z result was zero |
| bus_err | output | 1 | Several bus drivers enabled |

## Verification
The arithmetic unit is tried on operand pairs chosen to separate its cases. Plain sums are used, along with carry-in wrapping to zero, subtraction borrowing below zero, and equal operands giving zero. Products that fit are paired with products whose low half is zero, and ordinary quotients with a zero divisor. Each pattern also shows whether the zero flag tracks the result. Bus contention is tried with different pairs of sources, so a wrong priority order shows up. Full fetch, add and jump sequences confirm that Y clearing, carry injection and memory completion work together as the controller expects.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int W = 16,
  parameter int NREG = 4,
  parameter int AFW = 12,
  parameter logic [W-1:0] RESET_PC = 16'd1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_out,
  input  logic            pc_in,
  input  logic            mar_in,
  input  logic            rd_start,
  input  logic            mdr_out,
  input  logic            ir_in,
  input  logic            ir_addr_out,
  input  logic            y_in,
  input  logic            y_clr,
  input  logic            z_in,
  input  logic            z_out,
  input  logic [NREG-1:0] reg_out,
  input  logic [NREG-1:0] reg_in,
  input  logic            carry,
  input  logic [1:0]      alu_op,
  output logic [W-1:0]    mem_addr,
  output logic            rd_req,
  input  logic [W-1:0]    mem_rdata,
  input  logic            mem_done,
  output logic [W-1:0]    bus_o,
  output logic [W-1:0]    pc_o,
  output logic            zero_o,
  output logic            bus_err
);
  localparam int NSRC = NREG + 4;

  logic [W-1:0] pc, mar, mdr, ir, y, z, res, a_op;
  logic [W-1:0] gpr [NREG];
  logic [W-1:0] bus;
  logic [NSRC-1:0] outs;
  logic zf, pend;

  assign outs    = {pc_out, mdr_out, ir_addr_out, z_out, reg_out};
  assign bus_err = $countones(outs) > 1;

  always_comb begin
    bus = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (reg_out[i]) bus = gpr[i];
    if (z_out)       bus = z;
    if (ir_addr_out) bus = {{(W-AFW){1'b0}}, ir[AFW-1:0]};
    if (mdr_out)     bus = mdr;
    if (pc_out)      bus = pc;
  end

  assign a_op = y_clr ? '0 : y;

  always_comb begin
    case (alu_op)
      2'd0:    res = a_op + bus + {{(W-1){1'b0}}, carry};
      2'd1:    res = a_op - bus;
      2'd2:    res = a_op * bus;
      default: res = (bus == '0) ? '1 : a_op / bus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= RESET_PC; mar <= '0; mdr <= '0; ir <= '0;
      y <= '0; z <= '0; zf <= 1'b0; pend <= 1'b0;
    end else begin
      if (pc_in) pc <= bus;
      if (ir_in) ir <= bus;
      if (y_clr) y <= '0;
      else if (y_in) y <= bus;
      if (z_in) begin
        z  <= res;
        zf <= (res == '0);
      end
      if (mar_in) mar <= bus;
      if (mar_in && rd_start) pend <= 1'b1;
      else if (mem_done) pend <= 1'b0;
      if (mem_done && pend) mdr <= mem_rdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) gpr[g] <= '0;
      else if (reg_in[g]) gpr[g] <= bus;
    end
  end

  assign bus_o    = bus;
  assign pc_o     = pc;
  assign mem_addr = mar;
  assign rd_req   = pend;
  assign zero_o   = zf;
endmodule

module sbus_datapath_chk #(
  parameter int W = 16,
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pc_out,
  input logic            pc_in,
  input logic            mdr_out,
  input logic            z_out,
  input logic            mar_in,
  input logic            rd_start,
  input logic            mem_done,
  input logic            rd_req,
  input logic [W-1:0]    mem_addr,
  input logic [W-1:0]    pc_o,
  input logic [W-1:0]    bus_o,
  input logic            bus_err
);
  assert_pc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_in |=> pc_o == $past(bus_o));
  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_in |=> $stable(pc_o));
  assert_pc_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_out |-> bus_o == pc_o);
  assert_conflict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_out && (mdr_out || z_out)) |-> bus_err);
  assert_rd_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_in && rd_start) |=> rd_req && mem_addr == $past(bus_o));
  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !mem_done && !mar_in) |=> rd_req && $stable(mem_addr));
  assert_rd_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && mem_done && !(mar_in && rd_start)) |=> !rd_req);
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W), .NREG(NREG)) chk_i (.*);

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb_top;
  localparam int W = 16;
  localparam int NREG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pc_out, pc_in, mar_in, rd_start, mdr_out, ir_in, ir_addr_out;
  logic y_in, y_clr, z_in, z_out, carry, mem_done;
  logic [NREG-1:0] reg_out, reg_in;
  logic [1:0] alu_op;
  logic [W-1:0] mem_rdata, mem_addr, bus_o, pc_o;
  logic rd_req, zero_o, bus_err;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sbus_datapath dut_i (.*);

  // {op, carry, y, bus, expected}
  localparam logic [50:0] VEC [8] = '{
    {2'd0, 1'b0, 16'd5,     16'd7,   16'd12},
    {2'd0, 1'b1, 16'hFFFF,  16'd0,   16'd0},
    {2'd1, 1'b0, 16'd3,     16'd5,   16'hFFFE},
    {2'd1, 1'b1, 16'd9,     16'd9,   16'd0},
    {2'd2, 1'b0, 16'h0100,  16'h0100,16'h0000},
    {2'd2, 1'b0, 16'd300,   16'd7,   16'd2100},
    {2'd3, 1'b0, 16'd100,   16'd7,   16'd14},
    {2'd3, 1'b0, 16'd5,     16'd0,   16'hFFFF}
  };

  function automatic logic [W-1:0] mem_word(input logic [W-1:0] a);
    case (a)
      16'd1000: return 16'h10C8;
      16'd1001: return 16'h2010;
      16'd200:  return 16'd12;
      default:  return a ^ 16'h5A5A;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic clr();
    {pc_out, pc_in, mar_in, rd_start, mdr_out, ir_in, ir_addr_out} = '0;
    {y_in, y_clr, z_in, z_out, carry, mem_done} = '0;
    reg_out = '0; reg_in = '0; alu_op = 2'd0; mem_rdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  task automatic mem_read(input logic [W-1:0] v);
    mar_in = 1; rd_start = 1; tick();
    mem_done = 1; mem_rdata = v; tick();
  endtask

  task automatic fetch();
    pc_out = 1; mar_in = 1; rd_start = 1; y_clr = 1; carry = 1; z_in = 1; tick();
    z_out = 1; pc_in = 1; mem_done = 1; mem_rdata = mem_word(mem_addr); tick();
    mdr_out = 1; ir_in = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pc reset", pc_o, 16'd1000);
    chk("R1 rd_req reset", {15'd0, rd_req}, 16'd0);
    chk("R2 idle bus", bus_o, 16'd0);
    z_out = 1; #1 chk("R1 z reset", bus_o, 16'd0); z_out = 0;
    reg_out = 4'b1000; #1 chk("R1 reg reset", bus_o, 16'd0); reg_out = 0;
    @(negedge clk); rst_n = 1; clr(); @(negedge clk);

    foreach (VEC[i]) begin
      mem_read(VEC[i][47:32]);
      mdr_out = 1; y_in = 1; tick();
      mem_read(VEC[i][31:16]);
      mdr_out = 1; z_in = 1; alu_op = VEC[i][50:49]; carry = VEC[i][48]; tick();
      z_out = 1; #1;
      chk($sformatf("R4 vector %0d", i), bus_o, VEC[i][15:0]);
      chk($sformatf("R7 zero flag vector %0d", i), {15'd0, zero_o},
          {15'd0, VEC[i][15:0] == 16'd0});
      tick();
    end

    mar_in = 1; rd_start = 1; tick();
    #1 chk("R6 rd_req raised", {15'd0, rd_req}, 16'd1);
    @(negedge clk);
    #1 chk("R6 rd_req held", {15'd0, rd_req}, 16'd1);
    mem_done = 1; mem_rdata = 16'h1234; tick();
    #1 chk("R6 rd_req dropped", {15'd0, rd_req}, 16'd0);
    mem_done = 1; mem_rdata = 16'hBEEF; tick();
    mdr_out = 1; #1 chk("R6 stray done ignored", bus_o, 16'h1234); clr();

    pc_out = 1; mdr_out = 1; #1;
    chk("R3 pc+mdr err", {15'd0, bus_err}, 16'd1);
    chk("R2 pc beats mdr", bus_o, pc_o);
    pc_out = 0; z_out = 1; #1 chk("R2 mdr beats z", bus_o, 16'h1234);
    clr(); reg_out = 4'b0010; #1 chk("R3 single source no err", {15'd0, bus_err}, 16'd0);
    clr();

    mdr_out = 1; y_in = 1; tick();
    mdr_out = 1; y_in = 1; y_clr = 1; tick();
    mdr_out = 1; z_in = 1; tick();
    z_out = 1; #1 chk("R5 clear beats load", bus_o, 16'h1234); clr();
    mdr_out = 1; y_in = 1; tick();
    mdr_out = 1; y_clr = 1; carry = 1; z_in = 1; tick();
    z_out = 1; #1 chk("R5 increment", bus_o, 16'h1235); clr();
    z_out = 1; #1 chk("R7 zero low", {15'd0, zero_o}, 16'd0); clr();

    rst_n = 0; tick(); rst_n = 1; tick();
    mem_read(16'd30);
    mdr_out = 1; reg_in = 4'b0010; tick();
    fetch();
    ir_addr_out = 1; #1 chk("R2 address field", bus_o, 16'd200);
    mar_in = 1; rd_start = 1; tick();
    reg_out = 4'b0010; y_in = 1; mem_done = 1; mem_rdata = mem_word(mem_addr); tick();
    mdr_out = 1; z_in = 1; tick();
    z_out = 1; reg_in = 4'b0010; tick();
    reg_out = 4'b0010; #1 chk("R9 R8 R1 sum", bus_o, 16'd42); clr();
    chk("R9 pc after add", pc_o, 16'd1001);

    fetch();
    chk("R5 pc incremented", pc_o, 16'd1002);
    pc_out = 1; y_in = 1; tick();
    ir_addr_out = 1; z_in = 1; tick();
    z_out = 1; pc_in = 1; tick();
    chk("R10 jump target", pc_o, 16'd1018);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule